// File: doc/BRIEF.md
# One-Hot Peripheral Register Bank

This block is the register bank for the peripherals of a small soft-core system. It answers to a single region of the address space. Inside that region each register owns one dedicated address bit rather than a full offset compare. One store can therefore land in several registers at once. A read that touches several registers gets the bitwise OR of their contents.

The bank holds a 4-bit LED register and a 2-bit display control code. It returns read-only words for the hardware configuration and the installed RAM size. It gives access to an external UART through two separate views:

- **Status view.** Polling it has no side effect.
- **Data view.** A write raises a transmit strobe and a read raises a receive-acknowledge strobe.

Writes to the display command, display data and LED matrix data registers appear as one-cycle strobes. The neighbouring controllers take the data from the bus write word.

The bus is a plain strobe bus with no handshake. The bank never stalls. Every access completes in the cycle in which its strobe is high, and there is no back-pressure to honour. Write effects appear on the register outputs after that clock edge. Read data is registered: it appears after the edge that samples `bus_rd` and holds until the next read.

Top module: `oh_io_bank`

## Requirements
- R1: An access whose address bits [23:22] are not 2'b01 raises no strobe and changes no register. A read of such an address returns 0.
- R2: A write with address bit 2 set loads write data bits [3:0] into `led_o` at that clock edge. A read with bit 2 set returns `led_o` in bits [3:0].
- R3: A write that sets several selector bits updates every selected register and raises every selected strobe in the same cycle.
- R4: A read returns the bitwise OR of the words of all selected registers, or 0 if none is selected. `bus_rdata` changes only after a cycle with `bus_rd` high.
- R5: A read with address bit 13 set returns `uart_busy` in bit 9 and `uart_valid` in bit 8. Unless bit 7 is also set, it raises neither `uart_rx_ack` nor `uart_tx_wr`.
- R6: A write with address bit 7 set raises `uart_tx_wr` for exactly the cycle of that write.
- R7: A read with address bit 7 set raises `uart_rx_ack` for exactly that cycle and returns `uart_rx_byte` in bits [7:0].
- R8: A write with address bit 3 set loads write data bits [1:0] into `disp_mode_o`. The codes are 01 for reset low, 11 for reset high and 00 for normal operation. A read with bit 3 set returns `disp_busy` in bit 0.
- R9: A read with address bit 8 set returns the RAM size 0x1800. A read with bit 6 set returns the configuration word `CFG_WORD`.
- R10: Writes with address bit 4, 5 or 9 set raise `disp_cmd_wr`, `disp_data_wr` or `mtx_data_wr` respectively for that cycle. Reads of these bits contribute 0.
- R11: After reset `led_o`, `disp_mode_o` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| led_o | output | 4 | LED outputs |
| disp_mode_o | output | 2 | Display reset control code |
| disp_busy | input | 1 | Display controller busy |
| disp_cmd_wr | output | 1 | Display command write strobe |
| disp_data_wr | output | 1 | Display data write strobe |
| mtx_data_wr | output | 1 | LED matrix data write strobe |
| uart_busy | input | 1 | UART transmitter busy |
| uart_valid | input | 1 | UART receive byte valid |
| uart_rx_byte | input | 8 | UART received byte |
| uart_tx_wr | output | 1 | UART transmit strobe |
| uart_rx_ack | output | 1 | UART receive acknowledge strobe |

## Verification
The properties take for granted that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume the address and UART inputs are steady within each clock period. The stimulus drives each bus cycle as either a write or a read, and changes inputs only at the falling edge.

Every combination of the nine selector bits is written and then read back inside the region. The UART and display inputs are varied per combination so that OR-merged reads reveal each contributor. Accesses with the other three region codes show that nothing outside the region has an effect.

// File: rtl/oh_io_pkg.sv
package oh_io_pkg;
  // selector bit positions in the byte address (one-hot decode)
  localparam int BIT_LED   = 2;
  localparam int BIT_DCTL  = 3;
  localparam int BIT_DCMD  = 4;
  localparam int BIT_DDAT  = 5;
  localparam int BIT_CFG   = 6;
  localparam int BIT_UDAT  = 7;
  localparam int BIT_RAM   = 8;
  localparam int BIT_MTX   = 9;
  localparam int BIT_USTAT = 13;
  // uart status word fields
  localparam int UST_VALID = 8;
  localparam int UST_BUSY  = 9;

  typedef struct packed {
    logic ustat;
    logic mtx;
    logic ram;
    logic udat;
    logic cfg;
    logic ddat;
    logic dcmd;
    logic dctl;
    logic led;
  } io_sel_t;
endpackage

// File: rtl/oh_io_decode.sv
module oh_io_decode
  import oh_io_pkg::*;
#(
  parameter int         ADDR_W = 24,
  parameter logic [1:0] REGION = 2'b01
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output io_sel_t           sel
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    hit       = (addr[TOP -: 2] == REGION);
    sel.led   = hit & addr[BIT_LED];
    sel.dctl  = hit & addr[BIT_DCTL];
    sel.dcmd  = hit & addr[BIT_DCMD];
    sel.ddat  = hit & addr[BIT_DDAT];
    sel.cfg   = hit & addr[BIT_CFG];
    sel.udat  = hit & addr[BIT_UDAT];
    sel.ram   = hit & addr[BIT_RAM];
    sel.mtx   = hit & addr[BIT_MTX];
    sel.ustat = hit & addr[BIT_USTAT];
  end
endmodule

// File: rtl/oh_io_regs.sv
module oh_io_regs
  import oh_io_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 4,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  io_sel_t           sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [LED_W-1:0]  led_q,
  output logic [MODE_W-1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_q  <= '0;
      mode_q <= '0;
    end else begin
      if (wr && sel.led)  led_q  <= wdata[LED_W-1:0];
      if (wr && sel.dctl) mode_q <= wdata[MODE_W-1:0];
    end
  end

  // R2
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel.led) |=> $stable(led_q));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel.dctl) |=> $stable(mode_q));
  // R3
  multi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel.led && sel.dctl) |=>
      (led_q == $past(wdata[LED_W-1:0])) && (mode_q == $past(wdata[MODE_W-1:0])));
endmodule

// File: rtl/oh_io_strobes.sv
module oh_io_strobes
  import oh_io_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  logic    rd,
  input  logic    hit,
  input  io_sel_t sel,
  output logic    tx_wr,
  output logic    rx_ack,
  output logic    cmd_wr,
  output logic    dat_wr,
  output logic    mtx_wr
);
  always_comb begin
    tx_wr  = wr & sel.udat;
    rx_ack = rd & sel.udat;
    cmd_wr = wr & sel.dcmd;
    dat_wr = wr & sel.ddat;
    mtx_wr = wr & sel.mtx;
  end

  // R1
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !(tx_wr || rx_ack || cmd_wr || dat_wr || mtx_wr));
  // R5
  status_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.ustat && !sel.udat) |-> !(rx_ack || tx_wr));
  // R6
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !wr) |-> 1'b0);
endmodule

// File: rtl/oh_io_readback.sv
module oh_io_readback
  import oh_io_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          LED_W     = 4,
  parameter int          MODE_W    = 2,
  parameter logic [31:0] RAM_BYTES = 32'h0000_1800,
  parameter logic [31:0] CFG_WORD  = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  io_sel_t           sel,
  input  logic [LED_W-1:0]  led_q,
  input  logic              disp_busy,
  input  logic              uart_busy,
  input  logic              uart_valid,
  input  logic [7:0]        uart_rx_byte,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] merged;

  always_comb begin
    merged = '0;
    if (sel.led)   merged[LED_W-1:0] = led_q;
    if (sel.dctl)  merged[0] = merged[0] | disp_busy;
    if (sel.cfg)   merged = merged | CFG_WORD[DATA_W-1:0];
    if (sel.udat)  merged[7:0] = merged[7:0] | uart_rx_byte;
    if (sel.ram)   merged = merged | RAM_BYTES[DATA_W-1:0];
    if (sel.ustat) begin
      merged[UST_BUSY]  = merged[UST_BUSY]  | uart_busy;
      merged[UST_VALID] = merged[UST_VALID] | uart_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= merged;
  end

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  // R9
  ram_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == io_sel_t'(9'h040)) |=> (rdata == RAM_BYTES[DATA_W-1:0]));
endmodule

// File: rtl/oh_io_bank.sv
module oh_io_bank
  import oh_io_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 32,
  parameter int          LED_W     = 4,
  parameter logic [1:0]  REGION    = 2'b01,
  parameter logic [31:0] RAM_BYTES = 32'h0000_1800,
  parameter logic [31:0] CFG_WORD  = 32'h0003_0032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LED_W-1:0]  led_o,
  output logic [1:0]        disp_mode_o,
  input  logic              disp_busy,
  output logic              disp_cmd_wr,
  output logic              disp_data_wr,
  output logic              mtx_data_wr,
  input  logic              uart_busy,
  input  logic              uart_valid,
  input  logic [7:0]        uart_rx_byte,
  output logic              uart_tx_wr,
  output logic              uart_rx_ack
);
  localparam int MODE_W = 2;

  logic    hit;
  io_sel_t sel;

  oh_io_decode #(.ADDR_W(ADDR_W), .REGION(REGION)) u_dec (
    .addr(bus_addr), .hit(hit), .sel(sel));

  oh_io_regs #(.DATA_W(DATA_W), .LED_W(LED_W), .MODE_W(MODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .led_q(led_o), .mode_q(disp_mode_o));

  oh_io_strobes u_stb (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .hit(hit), .sel(sel),
    .tx_wr(uart_tx_wr), .rx_ack(uart_rx_ack), .cmd_wr(disp_cmd_wr),
    .dat_wr(disp_data_wr), .mtx_wr(mtx_data_wr));

  oh_io_readback #(.DATA_W(DATA_W), .LED_W(LED_W), .MODE_W(MODE_W),
                   .RAM_BYTES(RAM_BYTES), .CFG_WORD(CFG_WORD)) u_rb (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(sel), .led_q(led_o),
    .disp_busy(disp_busy), .uart_busy(uart_busy), .uart_valid(uart_valid),
    .uart_rx_byte(uart_rx_byte), .rdata(bus_rdata));
endmodule

// File: tb/oh_io_bank_bench.sv
module oh_io_bank_bench;
  localparam int          PERIOD = 10;
  localparam logic [31:0] CFG    = 32'h0003_0032;
  localparam logic [31:0] RAMSZ  = 32'h0000_1800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  led_o;
  logic [1:0]  disp_mode_o;
  logic        disp_busy = 1'b0;
  logic        disp_cmd_wr, disp_data_wr, mtx_data_wr;
  logic        uart_busy = 1'b0, uart_valid = 1'b0;
  logic [7:0]  uart_rx_byte = '0;
  logic        uart_tx_wr, uart_rx_ack;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic [3:0] led_m = '0;
  logic [1:0] mode_m = '0;

  always #(PERIOD/2) clk = ~clk;

  oh_io_bank #(.CFG_WORD(CFG)) u_oh_io_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .led_o(led_o),
    .disp_mode_o(disp_mode_o), .disp_busy(disp_busy), .disp_cmd_wr(disp_cmd_wr),
    .disp_data_wr(disp_data_wr), .mtx_data_wr(mtx_data_wr), .uart_busy(uart_busy),
    .uart_valid(uart_valid), .uart_rx_byte(uart_rx_byte), .uart_tx_wr(uart_tx_wr),
    .uart_rx_ack(uart_rx_ack));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // selector index -> byte address bits 2..9 and 13
  function automatic logic [23:0] spread(input logic [8:0] s, input logic [1:0] rg);
    logic [23:0] a;
    a = {rg, 22'h0};
    a[9:2] = s[7:0];
    a[13]  = s[8];
    return a;
  endfunction

  function automatic logic [4:0] strobes();
    return {uart_tx_wr, uart_rx_ack, disp_cmd_wr, disp_data_wr, mtx_data_wr};
  endfunction

  function automatic logic [31:0] exp_read(input logic [8:0] s);
    logic [31:0] v;
    v = '0;
    if (s[0]) v = v | {28'h0, led_m};
    if (s[1]) v = v | {31'h0, disp_busy};
    if (s[4]) v = v | CFG;
    if (s[5]) v = v | {24'h0, uart_rx_byte};
    if (s[6]) v = v | RAMSZ;
    if (s[8]) v = v | ({22'h0, uart_busy, uart_valid, 8'h0});
    return v;
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 led", {28'h0, led_o}, 32'h0);
    chk("R11 mode", {30'h0, disp_mode_o}, 32'h0);
    chk("R11 rdata", bus_rdata, 32'h0);

    for (int s = 0; s < 512; s++) begin
      logic [8:0] sv;
      logic [31:0] wd;
      logic [31:0] ex;
      sv = s[8:0];
      wd = 32'h9E37_79B9 * (s + 1);
      // write cycle
      bus_addr = spread(sv, 2'b01); bus_wdata = wd; bus_wr = 1'b1;
      #1;
      chk("R3 R6 R10 write strobes", {27'h0, strobes()},
          {27'h0, sv[5], 1'b0, sv[2], sv[3], sv[7]});
      @(negedge clk);
      bus_wr = 1'b0;
      if (sv[0]) led_m  = wd[3:0];
      if (sv[1]) mode_m = wd[1:0];
      chk("R2 R3 led", {28'h0, led_o}, {28'h0, led_m});
      chk("R8 R3 mode", {30'h0, disp_mode_o}, {30'h0, mode_m});
      #1;
      chk("R6 strobe one cycle", {27'h0, strobes()}, 32'h0);
      // read cycle
      uart_busy = sv[3]; uart_valid = sv[4] ^ sv[0];
      uart_rx_byte = sv[7:0] ^ 8'hA5; disp_busy = sv[1] ^ sv[8];
      bus_rd = 1'b1;
      #1;
      chk("R5 R7 read strobes", {27'h0, strobes()}, {28'h0, sv[5], 3'b000});
      ex = exp_read(sv);
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R4 R5 R7 R8 R9 R10 rdata", bus_rdata, ex);
      uart_rx_byte = ~uart_rx_byte; uart_busy = ~uart_busy;
      @(negedge clk);
      chk("R4 rdata hold", bus_rdata, ex);
    end

    // outside the region: all selectors, other region codes
    for (int r = 0; r < 4; r++) begin
      if (r == 1) continue;
      bus_addr = spread(9'h1FF, r[1:0]); bus_wdata = ~{8{led_m}}; bus_wr = 1'b1;
      #1;
      chk("R1 write strobes", {27'h0, strobes()}, 32'h0);
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R1 led kept", {28'h0, led_o}, {28'h0, led_m});
      chk("R1 mode kept", {30'h0, disp_mode_o}, {30'h0, mode_m});
      bus_rd = 1'b1;
      #1;
      chk("R1 read strobes", {27'h0, strobes()}, 32'h0);
      @(negedge clk);
      bus_rd = 1'b0;
      chk("R1 rdata zero", bus_rdata, 32'h0);
    end

    // named single reads of constants
    bus_addr = 24'h400100; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R9 ram size", bus_rdata, 32'h0000_1800);
    bus_addr = 24'h400040; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R9 config word", bus_rdata, CFG);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule